// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block runs program and erase operations on a serial NOR flash by itself. A request carries the operation (sector erase or word program), a 24-bit start address and a byte count. When the block accepts a request, it builds every serial frame the operation needs. The byte shifter runs in mode 0 and sends the most significant bit first. The serial clock is derived from the system clock through a divider that can be changed at run time.

Each operation begins with a write-enable frame and ends with a write-disable frame. After each of these frames, and after every erase or program frame, the block reads the status register repeatedly. It waits a fixed gap between two reads and stops after a fixed number of reads. An erase request is divided into whole 1 KiB sectors, and each sector is a complete operation of its own. A program request sends the address only once. Every later 2-byte word is sent behind the opcode alone, and the flash advances its own internal address. Program data comes in through a byte stream with a valid/ready handshake. The block fetches two bytes just before it sends each word.

When an operation finishes, the block pulses `done`. It pulses `error` when it rejects a request or when a status poll runs out of reads. A poll that runs out also sets a sticky `timeout_flag`.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy`, `done`, `error` and `timeout_flag` are 0, and `wr_ready` is 0.
- R2: Serial transfers use mode 0. SCK idles low, MOSI changes only while SCK is low, MISO is sampled on the rising edge, and bytes go out MSB first. Within a byte, each half period of SCK lasts `clk_div`+1 system clocks.
- R3: Every sector erase and every program operation starts with the one-byte frame 0x06. It is followed by status frames (0x05, then dummy 0x00 while the status byte is read back) until status bits [1:0] read 2'b10: bit 0 is busy, bit 1 is the write-enable latch.
- R4: A sector erase sends the 4-byte frame 0xD7, A[23:16], A[15:8], A[7:0]. Status frames then follow until bit 0 reads 0.
- R5: An erase of `len` bytes covers ceil(`len`/1024) sectors. Each sector gets its own enable, erase and disable sequence, and the address grows by 0x400 from one sector to the next, carrying into the upper address bytes.
- R6: A program operation sends its first word as the 6-byte frame 0xAD, A[23:16], A[15:8], A[7:0], D0, D1. Status frames then follow until bit 0 reads 0.
- R7: Each further word is sent as the 3-byte frame 0xAD, D0, D1, followed by a busy poll. Data bytes are taken from the stream in arrival order, and `wr_ready` is high only while chip select is deasserted.
- R8: After the last sector or word, the block sends the one-byte frame 0x04, polls until bit 0 reads 0, and then pulses `done` for one cycle in the same cycle that `busy` falls. `done` and `error` never pulse together.
- R9: Status bits [7:2] are ignored. After a failed status read, chip select stays high for at least `POLL_GAP` clocks before the next read.
- R10: When `POLL_LIMIT` status reads in one poll all fail, the block leaves chip select high, pulses `error`, sets `timeout_flag`, sends no 0x04 frame and returns to idle. `timeout_flag` stays set until reset, including through later operations that succeed.
- R11: A request whose length is zero, or a program request whose length is odd, is rejected. `error` pulses in the next cycle, `busy` stays low and no frame is sent.
- R12: `busy` is high from the cycle after a request is accepted until the end of that operation. While `busy` is high, `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| op_prog | input | 1 | 1: word program, 0: sector erase |
| addr | input | 24 | Start address in the flash |
| len | input | LEN_W | Byte count |
| clk_div | input | DIV_W | SCK half period minus one, in system clocks |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte is present |
| wr_ready | output | 1 | Block takes the data byte this cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| error | output | 1 | One-cycle pulse on reject or poll timeout |
| timeout_flag | output | 1 | Sticky poll timeout indicator |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- An erase whose sector address crosses a 64 KiB boundary. A sector counter with the wrong rounding sends one sector too few or too many, and a bad address step leaves the carry out of the upper byte.
- Status reads that come back busy or without the enable latch, with junk in the upper bits. A design that compares the whole byte, or skips the wait between reads, sends a different number of status frames or leaves too short a gap.
- A flash that stays busy. A wrong retry limit shows up as a wrong count of status reads, and a design that still sends the disable frame on timeout shows up as an extra frame.
- Zero and odd lengths, and a second request made while one is running. A design that leaks these through produces frames where none should appear.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_SERASE = 8'hD7;
    localparam logic [7:0] OPC_WPROG = 8'hAD;

    typedef enum logic [2:0] {
        FR_WREN,
        FR_WRDI,
        FR_STAT,
        FR_ERASE,
        FR_PROG_FIRST,
        FR_PROG_NEXT
    } frame_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_XFER,
        SQ_CSGAP,
        SQ_WAIT
    } seq_e;

    typedef struct packed {
        logic [23:0] addr;
        logic [7:0]  d0;
        logic [7:0]  d1;
    } frame_ctx_t;

    function automatic logic [2:0] frame_len(frame_e f);
        case (f)
            FR_STAT:       return 3'd2;
            FR_ERASE:      return 3'd4;
            FR_PROG_FIRST: return 3'd6;
            FR_PROG_NEXT:  return 3'd3;
            default:       return 3'd1;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(frame_e f, logic [2:0] idx, frame_ctx_t c);
        logic [7:0] b;
        b = 8'h00;
        case (f)
            FR_WREN: b = OPC_WREN;
            FR_WRDI: b = OPC_WRDI;
            FR_STAT: b = (idx == 3'd0) ? OPC_RDSR : 8'h00;
            FR_ERASE, FR_PROG_FIRST: begin
                case (idx)
                    3'd0: b = (f == FR_ERASE) ? OPC_SERASE : OPC_WPROG;
                    3'd1: b = c.addr[23:16];
                    3'd2: b = c.addr[15:8];
                    3'd3: b = c.addr[7:0];
                    3'd4: b = c.d0;
                    default: b = c.d1;
                endcase
            end
            FR_PROG_NEXT: begin
                case (idx)
                    3'd0: b = OPC_WPROG;
                    3'd1: b = c.d0;
                    default: b = c.d1;
                endcase
            end
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic logic status_ok(logic [7:0] s, logic want_wel);
        if (want_wel) return (s[1:0] == 2'b10);
        return !s[0];
    endfunction

endpackage

// File: rtl/sfs_byte_shifter.sv
module sfs_byte_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  logic [7:0]       tx,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx
);
    logic [DIV_W-1:0] tick_cnt;
    logic [2:0]       bit_cnt;
    logic             phase;
    logic             active;
    logic [7:0]       sh;
    logic             tick;

    assign tick = active && (tick_cnt == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            bit_cnt  <= '0;
            phase    <= 1'b0;
            active   <= 1'b0;
            sh       <= '0;
            rx       <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !active) begin
                active   <= 1'b1;
                sh       <= tx;
                bit_cnt  <= '0;
                phase    <= 1'b0;
                tick_cnt <= '0;
            end else if (active) begin
                if (tick) begin
                    tick_cnt <= '0;
                    if (!phase) begin
                        phase <= 1'b1;
                        rx    <= {rx[6:0], miso};
                    end else begin
                        phase <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            sh      <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end
        end
    end

    assign sck  = phase;
    assign mosi = sh[7];
    assign busy = active;

endmodule

// File: rtl/sfs_poll_timer.sv
module sfs_poll_timer #(
    parameter int POLL_GAP   = 1500,
    parameter int POLL_LIMIT = 1334
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic miss,
    output logic last_try,
    output logic gap_done
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int LIM_W = $clog2(POLL_LIMIT + 1);

    logic [LIM_W-1:0] misses;
    logic [GAP_W-1:0] gcnt;
    logic             waiting;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            misses  <= '0;
            gcnt    <= '0;
            waiting <= 1'b0;
        end else if (miss) begin
            misses  <= misses + 1'b1;
            gcnt    <= '0;
            waiting <= 1'b1;
        end else if (waiting) begin
            if (gcnt == GAP_W'(POLL_GAP - 1)) waiting <= 1'b0;
            else gcnt <= gcnt + 1'b1;
        end
    end

    assign gap_done = waiting && (gcnt == GAP_W'(POLL_GAP - 1));
    assign last_try = (misses == LIM_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
    import sfs_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int LEN_W        = 16,
    parameter int POLL_GAP     = 1500,
    parameter int POLL_LIMIT   = 1334,
    parameter int SECTOR_BYTES = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_prog,
    input  logic [23:0]      addr,
    input  logic [LEN_W-1:0] len,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             timeout_flag
);
    localparam int SECT_SHIFT = $clog2(SECTOR_BYTES);
    localparam int SECT_CNT_W = LEN_W + 1 - SECT_SHIFT;

    seq_e       state;
    frame_e     frame, prev_frame;
    frame_ctx_t ctx;
    logic       is_prog, issued, want_wel, fetch_hi, first_word;
    logic [2:0] byte_idx;
    logic [7:0] stat_q;
    logic       cs_n_q, done_q, err_q, tmo_q;
    logic [SECT_CNT_W-1:0] sectors_left;
    logic [LEN_W-1:0]      words_left;

    logic       eng_load, eng_busy, eng_done;
    logic [7:0] eng_tx, eng_rx;
    logic       tmr_clear, tmr_miss, last_try, gap_done, stat_good;
    logic [LEN_W:0] len_round;
    logic [SECT_CNT_W-1:0] sect_req;
    logic       bad_req;

    assign len_round = {1'b0, len} + (LEN_W+1)'(SECTOR_BYTES - 1);
    assign sect_req  = len_round[LEN_W:SECT_SHIFT];
    assign bad_req   = (len == '0) || (op_prog && len[0]);

    assign eng_load  = (state == SQ_XFER) && !issued;
    assign eng_tx    = frame_byte(frame, byte_idx, ctx);
    assign stat_good = status_ok(stat_q, want_wel);
    assign tmr_clear = (state == SQ_CSGAP) && (frame != FR_STAT);
    assign tmr_miss  = (state == SQ_CSGAP) && (frame == FR_STAT) && !stat_good && !last_try;

    sfs_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .div  (clk_div),
        .load (eng_load),
        .tx   (eng_tx),
        .miso (spi_miso),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .busy (eng_busy),
        .done (eng_done),
        .rx   (eng_rx)
    );

    sfs_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (tmr_clear),
        .miss     (tmr_miss),
        .last_try (last_try),
        .gap_done (gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SQ_IDLE;
            frame        <= FR_WREN;
            prev_frame   <= FR_WREN;
            ctx          <= '0;
            is_prog      <= 1'b0;
            issued       <= 1'b0;
            want_wel     <= 1'b0;
            fetch_hi     <= 1'b0;
            first_word   <= 1'b0;
            byte_idx     <= '0;
            stat_q       <= '0;
            cs_n_q       <= 1'b1;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
            tmo_q        <= 1'b0;
            sectors_left <= '0;
            words_left   <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    cs_n_q <= 1'b1;
                    if (start) begin
                        if (bad_req) begin
                            err_q <= 1'b1;
                        end else begin
                            is_prog      <= op_prog;
                            ctx.addr     <= addr;
                            words_left   <= len >> 1;
                            sectors_left <= sect_req;
                            frame        <= FR_WREN;
                            byte_idx     <= '0;
                            issued       <= 1'b0;
                            state        <= SQ_XFER;
                        end
                    end
                end
                SQ_FETCH: begin
                    if (wr_valid) begin
                        if (!fetch_hi) begin
                            ctx.d0   <= wr_data;
                            fetch_hi <= 1'b1;
                        end else begin
                            ctx.d1     <= wr_data;
                            fetch_hi   <= 1'b0;
                            words_left <= words_left - LEN_W'(1);
                            frame      <= first_word ? FR_PROG_FIRST : FR_PROG_NEXT;
                            byte_idx   <= '0;
                            issued     <= 1'b0;
                            state      <= SQ_XFER;
                        end
                    end
                end
                SQ_XFER: begin
                    cs_n_q <= 1'b0;
                    if (eng_load) issued <= 1'b1;
                    if (eng_done) begin
                        if (byte_idx == frame_len(frame) - 3'd1) begin
                            cs_n_q <= 1'b1;
                            stat_q <= eng_rx;
                            state  <= SQ_CSGAP;
                            if (frame == FR_ERASE)
                                sectors_left <= sectors_left - SECT_CNT_W'(1);
                        end else begin
                            byte_idx <= byte_idx + 3'd1;
                            issued   <= 1'b0;
                        end
                    end
                end
                SQ_CSGAP: begin
                    cs_n_q   <= 1'b1;
                    byte_idx <= '0;
                    issued   <= 1'b0;
                    if (frame != FR_STAT) begin
                        prev_frame <= frame;
                        want_wel   <= (frame == FR_WREN);
                        frame      <= FR_STAT;
                        state      <= SQ_XFER;
                    end else if (stat_good) begin
                        case (prev_frame)
                            FR_WREN: begin
                                if (is_prog) begin
                                    first_word <= 1'b1;
                                    fetch_hi   <= 1'b0;
                                    state      <= SQ_FETCH;
                                end else begin
                                    frame <= FR_ERASE;
                                    state <= SQ_XFER;
                                end
                            end
                            FR_PROG_FIRST, FR_PROG_NEXT: begin
                                if (words_left != '0) begin
                                    first_word <= 1'b0;
                                    fetch_hi   <= 1'b0;
                                    state      <= SQ_FETCH;
                                end else begin
                                    frame <= FR_WRDI;
                                    state <= SQ_XFER;
                                end
                            end
                            FR_WRDI: begin
                                if (!is_prog && sectors_left != '0) begin
                                    ctx.addr <= ctx.addr + 24'(SECTOR_BYTES);
                                    frame    <= FR_WREN;
                                    state    <= SQ_XFER;
                                end else begin
                                    done_q <= 1'b1;
                                    state  <= SQ_IDLE;
                                end
                            end
                            default: begin
                                frame <= FR_WRDI;
                                state <= SQ_XFER;
                            end
                        endcase
                    end else if (last_try) begin
                        err_q <= 1'b1;
                        tmo_q <= 1'b1;
                        state <= SQ_IDLE;
                    end else begin
                        state <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    cs_n_q <= 1'b1;
                    if (gap_done) begin
                        frame <= FR_STAT;
                        state <= SQ_XFER;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign wr_ready     = (state == SQ_FETCH);
    assign spi_cs_n     = cs_n_q;
    assign busy         = (state != SQ_IDLE);
    assign done         = done_q;
    assign error        = err_q;
    assign timeout_flag = tmo_q;

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             op_prog,
    input logic [LEN_W-1:0] len,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic             timeout_flag,
    input logic             spi_cs_n,
    input logic             spi_sck,
    input logic             spi_mosi,
    input logic             wr_ready
);
    p_sck_low_when_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    p_mosi_steady_at_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sck) |-> $stable(spi_mosi));

    p_data_taken_deselected_r7: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> spi_cs_n);

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_error_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    p_timeout_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        timeout_flag |=> timeout_flag);

    p_timeout_raises_error_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> error && !busy && spi_cs_n);

    p_reject_bad_len_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (len == '0 || (op_prog && len[0]))) |=> (error && !busy));

    p_idle_deselected_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);

endmodule

bind spi_flash_seq sfs_checker #(.LEN_W(LEN_W)) u_sfs_checker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .op_prog      (op_prog),
    .len          (len),
    .busy         (busy),
    .done         (done),
    .error        (error),
    .timeout_flag (timeout_flag),
    .spi_cs_n     (spi_cs_n),
    .spi_sck      (spi_sck),
    .spi_mosi     (spi_mosi),
    .wr_ready     (wr_ready)
);

// File: tb/spi_flash_seq_test.sv
module spi_flash_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int LEN_W      = 16;
    localparam int POLL_GAP   = 5;
    localparam int POLL_LIMIT = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             op_prog = 1'b0;
    logic [23:0]      addr = '0;
    logic [LEN_W-1:0] len = '0;
    logic [DIV_W-1:0] clk_div = '0;
    logic [7:0]       wr_data;
    logic             wr_valid;
    logic             wr_ready, spi_cs_n, spi_sck, spi_mosi, spi_miso;
    logic             busy, done, error, timeout_flag;

    spi_flash_seq #(
        .DIV_W(DIV_W), .LEN_W(LEN_W), .POLL_GAP(POLL_GAP),
        .POLL_LIMIT(POLL_LIMIT), .SECTOR_BYTES(1024)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .op_prog(op_prog), .addr(addr),
        .len(len), .clk_div(clk_div), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy), .done(done),
        .error(error), .timeout_flag(timeout_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // program data stream
    logic [7:0] pdata [0:63];
    int feed_idx = 0;
    int feed_n   = 0;
    assign wr_valid = (feed_idx < feed_n);
    assign wr_data  = pdata[feed_idx % 64];
    always @(posedge clk) if (wr_valid && wr_ready) feed_idx <= feed_idx + 1;

    // flash model
    bit         mdl_on = 0;
    bit         stuck  = 0;
    bit         wel    = 0;
    int         wel_wait = 0, busy_left = 0;
    int         cfg_wd = 0, cfg_bk = 0;
    int         bitpos = 0;
    logic [7:0] cur_byte = '0;
    logic [7:0] logb [0:4095];
    int         flen [0:511];
    int         nfr = 0, nbytes = 0, frm_start = 0;
    int         fall_cyc = 0, last_rise_cyc = 0, last_rise_sck = 0;
    bit         prev_was_stat = 0;
    int         min_stat_gap = 1000000;
    int         min_sck_per  = 1000000;
    logic [7:0] stat_byte;

    assign stat_byte = {6'b111111, (wel && wel_wait == 0), (stuck || busy_left > 0)};
    assign spi_miso  = stat_byte[3'(7 - (bitpos % 8))];

    always @(negedge spi_cs_n) if (mdl_on) begin
        bitpos    = 0;
        frm_start = nbytes;
        fall_cyc  = cyc;
    end

    always @(posedge spi_sck) if (mdl_on && !spi_cs_n) begin
        if (bitpos % 8 != 0) begin
            if (cyc - last_rise_sck < min_sck_per) min_sck_per = cyc - last_rise_sck;
        end
        last_rise_sck = cyc;
        cur_byte = {cur_byte[6:0], spi_mosi};
        bitpos++;
        if (bitpos % 8 == 0) begin
            logb[nbytes] = cur_byte;
            nbytes++;
        end
    end

    always @(posedge spi_cs_n) if (mdl_on) begin
        logic [7:0] op;
        flen[nfr] = nbytes - frm_start;
        nfr++;
        op = logb[frm_start];
        if (op == 8'h05) begin
            if (prev_was_stat && (fall_cyc - last_rise_cyc) < min_stat_gap)
                min_stat_gap = fall_cyc - last_rise_cyc;
            if (busy_left > 0) busy_left--;
            if (wel_wait > 0) wel_wait--;
        end else if (op == 8'h06) begin
            wel = 1; wel_wait = cfg_wd;
        end else if (op == 8'h04) begin
            wel = 0;
        end else if (op == 8'hD7 || op == 8'hAD) begin
            busy_left = cfg_bk;
        end
        prev_was_stat = (op == 8'h05);
        last_rise_cyc = cyc;
    end

    // expected frame list
    logic [7:0] eb [0:4095];
    int         el [0:511];
    int         enf = 0, enb = 0;

    task automatic add_frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3,
                             input logic [7:0] b4, input logic [7:0] b5);
        logic [7:0] bs [0:5];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = b4; bs[5] = b5;
        for (int i = 0; i < n; i++) begin
            eb[enb] = bs[i];
            enb++;
        end
        el[enf] = n;
        enf++;
    endtask

    task automatic add_stat(input int count);
        for (int i = 0; i < count; i++) add_frame(2, 8'h05, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic clear_logs();
        nfr = 0; nbytes = 0; enf = 0; enb = 0;
        min_stat_gap = 1000000; min_sck_per = 1000000;
        prev_was_stat = 0;
    endtask

    task automatic compare_frames(input string req);
        int mism;
        int bi;
        mism = -1;
        chk(nfr == enf, req, "frame count", nfr, enf);
        if (nfr == enf) begin
            bi = 0;
            for (int f = 0; f < enf; f++) begin
                if (flen[f] != el[f] && mism < 0) mism = f;
            end
            if (mism < 0) begin
                for (int i = 0; i < enb; i++) begin
                    if (logb[i] != eb[i] && mism < 0) begin
                        mism = 10000 + i;
                        bi = i;
                    end
                end
            end
            if (mism >= 10000)
                chk(0, req, "frame byte", logb[bi], eb[bi]);
            else
                chk(mism < 0, req, "frame lengths (first bad frame index)", mism, -1);
        end
    endtask

    task automatic wait_end(output bit got_done, output bit got_err);
        int n;
        n = 0;
        got_done = 0; got_err = 0;
        while (!(done || error) && n < 30000) begin
            @(negedge clk);
            n++;
        end
        got_done = done;
        got_err  = error;
        if (n >= 30000) chk(0, "R8", "operation end watchdog", n, 30000);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_op(input bit prog, input logic [23:0] a, input int l,
                          input int dv, input int wd, input int bk, input bit inject);
        bit gd, ge;
        int nsec;
        logic [23:0] sa;
        clear_logs();
        cfg_wd = wd; cfg_bk = bk; stuck = 0;
        feed_idx = 0;
        feed_n   = prog ? l : 0;
        clk_div  = DIV_W'(dv);
        // expected frames
        if (!prog) begin
            nsec = (l + 1023) / 1024;
            for (int s = 0; s < nsec; s++) begin
                sa = a + 24'(s * 1024);
                add_frame(1, 8'h06, 0, 0, 0, 0, 0);
                add_stat(wd + 1);
                add_frame(4, 8'hD7, sa[23:16], sa[15:8], sa[7:0], 0, 0);
                add_stat(bk + 1);
                add_frame(1, 8'h04, 0, 0, 0, 0, 0);
                add_stat(1);
            end
        end else begin
            add_frame(1, 8'h06, 0, 0, 0, 0, 0);
            add_stat(wd + 1);
            add_frame(6, 8'hAD, a[23:16], a[15:8], a[7:0], pdata[0], pdata[1]);
            add_stat(bk + 1);
            for (int w = 1; w < l / 2; w++) begin
                add_frame(3, 8'hAD, pdata[2*w], pdata[2*w+1], 0, 0, 0);
                add_stat(bk + 1);
            end
            add_frame(1, 8'h04, 0, 0, 0, 0, 0);
            add_stat(1);
        end
        @(negedge clk);
        op_prog = prog; addr = a; len = LEN_W'(l); start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1, "R12", "busy after accept", busy, 1);
        if (inject) begin
            repeat (20) @(negedge clk);
            op_prog = 0; addr = 24'hFFFFFF; len = LEN_W'(4096); start = 1;
            @(negedge clk);
            start = 0;
        end
        wait_end(gd, ge);
        chk(gd && !ge, prog ? "R8" : "R5", "done without error", {gd, ge}, 2);
        chk(busy == 0, "R8", "idle after done", busy, 0);
        compare_frames(inject ? "R12" : (prog ? "R7" : "R5"));
        chk(min_sck_per == 2 * (dv + 1), "R2", "SCK period in clocks", min_sck_per, 2 * (dv + 1));
        if (wd + bk > 0)
            chk(min_stat_gap >= POLL_GAP, "R9", "gap after failed read", min_stat_gap, POLL_GAP);
        if (prog) chk(feed_idx == l, "R7", "data bytes consumed", feed_idx, l);
    endtask

    task automatic run_reject(input bit prog, input int l, input string req);
        clear_logs();
        feed_idx = 0; feed_n = 0;
        @(negedge clk);
        op_prog = prog; addr = 24'h001000; len = LEN_W'(l); start = 1;
        @(negedge clk);
        start = 0;
        chk(error == 1, req, "reject error pulse", error, 1);
        chk(busy == 0, req, "busy stays low", busy, 0);
        repeat (40) @(negedge clk);
        chk(nfr == 0 && spi_cs_n == 1, req, "no frame sent", nfr, 0);
    endtask

    task automatic do_reset();
        mdl_on = 0;
        rst = 1; start = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        mdl_on = 1;
        wel = 0; busy_left = 0; wel_wait = 0; stuck = 0;
    endtask

    // global watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit gd, ge;
        for (int i = 0; i < 64; i++) pdata[i] = 8'((i * 37 + 11) ^ 8'hA5);

        do_reset();
        // R1 reset state
        chk(spi_cs_n == 1 && spi_sck == 0, "R1", "serial pins at reset", {spi_cs_n, spi_sck}, 2);
        chk(!busy && !done && !error && !timeout_flag && !wr_ready, "R1", "status at reset",
            {busy, done, error, timeout_flag, wr_ready}, 0);

        for (int dv = 0; dv < 3; dv++) begin
            // R4: single sector, immediate status
            run_op(0, 24'h123456, 1, dv, 0, 0, 0);
            // R3, R9: latch and busy delayed
            run_op(0, 24'h0FFC00, 1025, dv, 2, 3, 0);
            // R6: one word
            run_op(1, 24'hABCDE0, 2, dv, 0, 1, 0);
            // R7: several words with retries
            run_op(1, 24'h00FFFE, 8, dv, 1, 2, 0);
        end
        // R5: exact multiple of sector size
        run_op(0, 24'h7FF800, 3072, 0, 0, 1, 0);
        // R12: start during busy is ignored
        run_op(1, 24'h040000, 6, 1, 0, 2, 1);

        // R11
        run_reject(1, 0, "R11");
        run_reject(0, 0, "R11");
        run_reject(1, 3, "R11");

        // R10: flash stuck busy
        clear_logs();
        cfg_wd = 0; cfg_bk = 0; feed_idx = 0; feed_n = 4; clk_div = 0;
        add_frame(1, 8'h06, 0, 0, 0, 0, 0);
        add_stat(POLL_LIMIT);
        @(negedge clk);
        stuck = 1;
        op_prog = 1; addr = 24'h002000; len = 4; start = 1;
        @(negedge clk);
        start = 0;
        wait_end(gd, ge);
        chk(ge && !gd, "R10", "timeout error pulse", {gd, ge}, 1);
        chk(timeout_flag == 1, "R10", "timeout flag set", timeout_flag, 1);
        chk(busy == 0 && spi_cs_n == 1, "R10", "idle after timeout", {busy, spi_cs_n}, 1);
        compare_frames("R10");
        stuck = 0;
        // R10: sticky through a successful operation
        run_op(0, 24'h003000, 1024, 0, 0, 0, 0);
        chk(timeout_flag == 1, "R10", "flag stays after later success", timeout_flag, 1);

        // R1 again
        do_reset();
        chk(timeout_flag == 0 && !busy && spi_cs_n, "R1", "reset clears flag", timeout_flag, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule